// File: doc/BRIEF.md
# Microprogram Address Sequencer with Execute-Once Branch

This block produces the control-store address for a microprogrammed control unit. Every cycle it registers one new address. The address comes from one of three sources: the current address plus one, a branch target carried in the current microinstruction, or a dispatch address built from opcode bits of the instruction register. A branch may also carry an execute-once option. With that option the sequencer runs only the single word at the target and then resumes at the word after the branch. A one-entry return register holds the resume point.

The microinstruction fields are applied combinationally for the word at the current address. These are the operation code, the execute-once bit, the index-modify bit, the target, the condition select and the index. The control store and the datapath sit outside the block.

The controller has two states. RUN is normal sequencing. ONCE is the single cycle in which a branch target is executing on behalf of an execute-once branch. There are three transitions:
- RUN→ONCE on a taken branch whose execute-once bit is set.
- ONCE→RUN always, on the next cycle.
- RUN→RUN otherwise.

Reset forces RUN.

Top module: `useq_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the address to 0 and returns the controller to RUN, discarding any pending return.
- R2: With operation 00 (step), the next address is the current address plus one, and it wraps from all ones to 0.
- R3: With operation 01 (jump), the next address is `target`.
- R4: With operation 10 (conditional jump), the branch is taken only when `flags[cond_sel]` is 1. When it is not taken, the next address is the current address plus one and the execute-once bit has no effect.
- R5: With operation 11 (dispatch), the next address is `DISP_BASE` plus the zero-extended `opcode`. The execute-once bit has no effect on a dispatch.
- R6: A taken jump or conditional jump with `once` = 1 goes to its target for exactly one cycle. The address after that is the branch word's address plus one.
- R7: During the single target cycle of an execute-once branch, all sequencing inputs are ignored.
- R8: When `idx_mod` = 1 on a jump or conditional jump, the target is `target` bitwise-ORed with the zero-extended `idx`. This may be combined with `once`.
- R9: A reset that arrives while a return is pending leaves no trace: after the reset, stepping proceeds 0, 1, 2 and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Sequencing operation: 00 step, 01 jump, 10 conditional jump, 11 dispatch |
| once | input | 1 | Execute-once option for jump and conditional jump |
| idx_mod | input | 1 | Index-modify option: OR `idx` into the branch target |
| target | input | AW | Branch target field of the current word |
| idx | input | IDXW | Index value used when `idx_mod` is set |
| cond_sel | input | $clog2(NFLAGS) | Selects the condition flag for operation 10 |
| flags | input | NFLAGS | Condition flags |
| opcode | input | DISP_BITS | Low opcode bits routed from the instruction register |
| addr | output | AW | Current control-store address |

## Verification
Each decision appears on `addr` one rising edge after its fields are applied, because the address register is the only register in the path. The resume address of an execute-once branch appears one edge later still, so it shows two edges after the branch word. The bench applies inputs at the falling edge and runs a reference model of the requirements. After each rising edge it queues the expected address. A monitor pops that entry at the following falling edge, which is when the registered address is stable.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [1:0] {
        OP_STEP = 2'b00,
        OP_JUMP = 2'b01,
        OP_CJMP = 2'b10,
        OP_DISP = 2'b11
    } useq_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_ONCE = 1'b1
    } useq_st_e;
endpackage

// File: rtl/useq_cond.sv
module useq_cond #(
    parameter int NFLAGS = 8,
    localparam int SELW  = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
    input  logic [NFLAGS-1:0] flags,
    input  logic [SELW-1:0]   sel,
    output logic              hit
);
    logic [NFLAGS-1:0] match;

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        assign match[i] = (sel == SELW'(i)) && flags[i];
    end

    assign hit = |match;
endmodule

// File: rtl/useq_src.sv
module useq_src #(
    parameter int            AW        = 12,
    parameter int            IDXW      = 4,
    parameter int            DISP_BITS = 6,
    parameter logic [AW-1:0] DISP_BASE = 12'h100
) (
    input  logic [AW-1:0]        addr,
    input  logic [AW-1:0]        target,
    input  logic                 idx_mod,
    input  logic [IDXW-1:0]      idx,
    input  logic [DISP_BITS-1:0] opcode,
    output logic [AW-1:0]        inc_addr,
    output logic [AW-1:0]        jmp_addr,
    output logic [AW-1:0]        disp_addr
);
    assign inc_addr  = addr + 1'b1;
    assign jmp_addr  = idx_mod ? (target | AW'(idx)) : target;
    assign disp_addr = DISP_BASE + AW'(opcode);
endmodule

// File: rtl/useq_ctl.sv
module useq_ctl
    import useq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  useq_op_e      op,
    input  logic          once,
    input  logic          cond_hit,
    input  logic [AW-1:0] inc_addr,
    input  logic [AW-1:0] jmp_addr,
    input  logic [AW-1:0] disp_addr,
    output logic [AW-1:0] addr,
    output logic          pend
);
    useq_st_e      st_q, st_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [AW-1:0] ret_q, ret_d;
    logic          take;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            addr_q <= '0;
            ret_q  <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            ret_q  <= ret_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        addr_d = inc_addr;
        ret_d  = ret_q;
        take   = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                unique case (op)
                    OP_STEP: addr_d = inc_addr;
                    OP_JUMP: take = 1'b1;
                    OP_CJMP: take = cond_hit;
                    OP_DISP: addr_d = disp_addr;
                endcase
                if (take) begin
                    addr_d = jmp_addr;
                    if (once) begin
                        st_d  = ST_ONCE;
                        ret_d = inc_addr;
                    end
                end
            end
            ST_ONCE: begin
                addr_d = ret_q;
                st_d   = ST_RUN;
            end
        endcase
    end

    assign addr = addr_q;
    assign pend = (st_q == ST_ONCE);
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int            AW        = 12,
    parameter int            IDXW      = 4,
    parameter int            NFLAGS    = 8,
    parameter int            DISP_BITS = 6,
    parameter logic [AW-1:0] DISP_BASE = 12'h100,
    localparam int           SELW      = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           op,
    input  logic                 once,
    input  logic                 idx_mod,
    input  logic [AW-1:0]        target,
    input  logic [IDXW-1:0]      idx,
    input  logic [SELW-1:0]      cond_sel,
    input  logic [NFLAGS-1:0]    flags,
    input  logic [DISP_BITS-1:0] opcode,
    output logic [AW-1:0]        addr
);
    logic          cond_hit;
    logic          xq_pend;
    logic [AW-1:0] inc_addr, jmp_addr, disp_addr;

    useq_cond #(.NFLAGS(NFLAGS)) u_cond (
        .flags (flags),
        .sel   (cond_sel),
        .hit   (cond_hit)
    );

    useq_src #(
        .AW(AW), .IDXW(IDXW), .DISP_BITS(DISP_BITS), .DISP_BASE(DISP_BASE)
    ) u_src (
        .addr      (addr),
        .target    (target),
        .idx_mod   (idx_mod),
        .idx       (idx),
        .opcode    (opcode),
        .inc_addr  (inc_addr),
        .jmp_addr  (jmp_addr),
        .disp_addr (disp_addr)
    );

    useq_ctl #(.AW(AW)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .op        (useq_op_e'(op)),
        .once      (once),
        .cond_hit  (cond_hit),
        .inc_addr  (inc_addr),
        .jmp_addr  (jmp_addr),
        .disp_addr (disp_addr),
        .addr      (addr),
        .pend      (xq_pend)
    );
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int            AW        = 12,
    parameter int            IDXW      = 4,
    parameter int            NFLAGS    = 8,
    parameter int            DISP_BITS = 6,
    parameter logic [AW-1:0] DISP_BASE = 12'h100,
    localparam int           SELW      = (NFLAGS > 1) ? $clog2(NFLAGS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           op,
    input logic                 once,
    input logic                 idx_mod,
    input logic [AW-1:0]        target,
    input logic [IDXW-1:0]      idx,
    input logic [SELW-1:0]      cond_sel,
    input logic [NFLAGS-1:0]    flags,
    input logic [DISP_BITS-1:0] opcode,
    input logic [AW-1:0]        addr,
    input logic                 pend
);
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (addr == '0 && !pend));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!pend && op == 2'b00) |=> (addr == AW'($past(addr) + 1'b1)));

    a_r3_jump: assert property (@(posedge clk) disable iff (rst)
        (!pend && op == 2'b01 && !idx_mod) |=> (addr == $past(target)));

    a_r4_fallthru: assert property (@(posedge clk) disable iff (rst)
        (!pend && op == 2'b10 && !flags[cond_sel])
        |=> (addr == AW'($past(addr) + 1'b1) && !pend));

    a_r5_dispatch: assert property (@(posedge clk) disable iff (rst)
        (!pend && op == 2'b11)
        |=> (addr == AW'(DISP_BASE + AW'($past(opcode))) && !pend));

    a_r6_resume: assert property (@(posedge clk) disable iff (rst)
        (!pend && op == 2'b01 && once)
        |=> pend ##1 (addr == AW'($past(addr, 2) + 1'b1)));

    a_r7_single: assert property (@(posedge clk) disable iff (rst)
        pend |=> !pend);

    a_r8_index: assert property (@(posedge clk) disable iff (rst)
        (!pend && op == 2'b01 && idx_mod)
        |=> (addr == ($past(target) | AW'($past(idx)))));
endmodule

bind useq_core useq_chk #(
    .AW(AW), .IDXW(IDXW), .NFLAGS(NFLAGS),
    .DISP_BITS(DISP_BITS), .DISP_BASE(DISP_BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .once     (once),
    .idx_mod  (idx_mod),
    .target   (target),
    .idx      (idx),
    .cond_sel (cond_sel),
    .flags    (flags),
    .opcode   (opcode),
    .addr     (addr),
    .pend     (xq_pend)
);

// File: tb/useq_core_tb.sv
module useq_core_tb;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    op = 2'b00;
    logic          once = 1'b0;
    logic          idx_mod = 1'b0;
    logic [AW-1:0] target = '0;
    logic [3:0]    idx = '0;
    logic [2:0]    cond_sel = '0;
    logic [7:0]    flags = '0;
    logic [5:0]    opcode = '0;
    logic [AW-1:0] addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_ret  = '0;
    logic          m_pend = 1'b0;

    always #5 clk = ~clk;

    useq_core u_dut (
        .clk(clk), .rst(rst), .op(op), .once(once), .idx_mod(idx_mod),
        .target(target), .idx(idx), .cond_sel(cond_sel), .flags(flags),
        .opcode(opcode), .addr(addr)
    );

    task automatic step(input string tag, input logic r, input logic [1:0] o,
                        input logic on, input logic im, input logic [AW-1:0] t,
                        input logic [2:0] s, input logic [7:0] f,
                        input logic [3:0] ix, input logic [5:0] oc);
        logic [AW-1:0] n;
        logic [AW-1:0] tgt;
        logic          tk;
        @(negedge clk);
        rst = r; op = o; once = on; idx_mod = im; target = t;
        cond_sel = s; flags = f; idx = ix; opcode = oc;
        tgt = im ? (t | AW'(ix)) : t;
        tk  = 1'b0;
        n   = m_addr + 1'b1;
        if (r) begin
            n = '0; m_pend = 1'b0;
        end else if (m_pend) begin
            n = m_ret; m_pend = 1'b0;
        end else begin
            case (o)
                2'b00: n = m_addr + 1'b1;
                2'b01: tk = 1'b1;
                2'b10: tk = f[s];
                default: n = 12'h100 + AW'(oc);
            endcase
            if (tk) begin
                n = tgt;
                if (on) begin
                    m_pend = 1'b1; m_ret = m_addr + 1'b1;
                end
            end
        end
        m_addr = n;
        @(posedge clk);
        #1;
        exp_q.push_back(n);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [AW-1:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (addr !== e) begin
                    fails++;
                    $display("FAIL %s: addr=%h expected=%h", tg, addr, e);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        // R1: reset state
        step("R1", 1, 0, 0, 0, '0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 0, '0, 0, 0, 0, 0);
        // R2: stepping
        step("R2", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        // R3: plain jump
        step("R3", 0, 1, 0, 0, 12'h0A0, 0, 0, 4'hF, 0);
        // R4: conditional taken on flag 2, then not taken with once set
        step("R4", 0, 2, 0, 0, 12'h200, 3'd2, 8'b0000_0100, 0, 0);
        step("R4", 0, 2, 1, 0, 12'h600, 3'd3, 8'b1111_0111, 0, 0);
        step("R4", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        // R5: dispatch with once set has no return effect
        step("R5", 0, 3, 1, 0, 12'h700, 0, 0, 0, 6'h2A);
        step("R5", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        // R6/R7: execute-once jump, target-cycle fields ignored
        step("R6", 0, 1, 1, 0, 12'h300, 0, 0, 0, 0);
        step("R7", 0, 1, 1, 0, 12'h777, 0, 8'hFF, 0, 6'h11);
        step("R6", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        // R8: index-modified conditional execute-once
        step("R8", 0, 2, 1, 1, 12'h340, 3'd7, 8'h80, 4'h5, 0);
        step("R8", 0, 3, 0, 0, '0, 0, 0, 0, 6'h3F);
        step("R8", 0, 1, 0, 1, 12'h4A0, 0, 0, 4'h3, 0);
        // R2: wrap from all ones
        step("R2", 0, 1, 0, 0, 12'hFFE, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        // R9: reset while a return is pending
        step("R9", 0, 1, 1, 0, 12'h050, 0, 0, 0, 0);
        step("R9", 1, 0, 0, 0, '0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, '0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule